// File: doc/BRIEF.md
# Card Bus Clock Divider

This block derives the serial clock for a memory-card bus from the peripheral clock. A 4-bit select code picks a power-of-two divide ratio: code n gives the peripheral clock divided by 2^(n+1), so code 0 gives /2 and code 8 gives /512. A gate input turns the card clock on or off. When the gate is off, the card clock is held low.

When a board strap allows it, the all-ones code selects passthrough. In that mode the divided output stays low and a bypass flag goes high, which tells the pad-side clock mux to route the peripheral clock itself. The edge strobe then fires on every peripheral cycle.

The command and data engines run on the peripheral clock. They use the single-cycle strobe that marks each card-clock rising edge. Software may change the select code at any time: a slow setting during card identification and a fast one during data transfer. A new code takes effect only at the start of the next output period, so no shortened pulse reaches the card.

Top module: `card_clk_div`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, card_clk_o, card_rise_o and bypass_o are all 0.
- R2: For select code n in 0..8, card_clk_o has a period of 2^(n+1) peripheral cycles. It is high for exactly 2^n of them and low for the other 2^n.
- R3: Codes 9 to 14, and code 15 when bypass_strap_i is 0, behave exactly like code 8 (period 512) and leave bypass_o at 0.
- R4: Code 15 with bypass_strap_i at 1 sets bypass_o to 1 and holds card_clk_o at 0. card_rise_o is then 1 in every cycle.
- R5: One cycle after clk_en_i is sampled low, card_clk_o and card_rise_o are 0. They stay 0 while clk_en_i stays low.
- R6: card_rise_o is high for exactly one cycle per divided period. That cycle is the first cycle in which card_clk_o is 1.
- R7: A select change made during a period does not alter that period. The new ratio applies from the next low phase onward.
- R8: Each period starts with its low phase. If clk_en_i is first sampled high at edge k while the clock is idle, card_clk_o rises at edge k+2^n-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clk_en_i | input | 1 | Card clock gate; 0 holds the output low |
| div_sel_i | input | 4 | Divide select code |
| bypass_strap_i | input | 1 | Strap that permits the passthrough code |
| card_clk_o | output | 1 | Divided card clock |
| card_rise_o | output | 1 | One-cycle strobe on each card clock rising edge |
| bypass_o | output | 1 | High when the peripheral clock is routed straight through |

## Verification
A corrupted phase counter or a corrupted latched ratio shows up at the ports within one output period. The symptom is a period or high-time count that is wrong, measured between two strobes. A strobe that is out of step with the clock level shows up in the very cycle it fires: the bench pairs each strobe sample with the clock level in that cycle and in the cycle before. Mid-period select changes are applied in both directions, slow to fast and fast to slow. The lengths of the transition period and of the period after it expose a ratio that was loaded too early.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    localparam int CODE_W   = 4;
    localparam int MAX_CODE = 8;
    localparam int SHIFT_W  = $clog2(MAX_CODE + 1);

    typedef struct packed {
        logic               byp;
        logic [SHIFT_W-1:0] shift;
    } div_mode_t;

endpackage

// File: rtl/card_clk_decode.sv
module card_clk_decode
    import card_clk_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int TOP_N = MAX_CODE
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             strap_i,
    output div_mode_t        mode_o
);

    localparam logic [SEL_W-1:0] PASS_CODE = {SEL_W{1'b1}};

    always_comb begin
        mode_o = '0;
        if (sel_i == PASS_CODE && strap_i) begin
            mode_o.byp = 1'b1;
        end else if (int'(sel_i) <= TOP_N) begin
            mode_o.shift = SHIFT_W'(sel_i);
        end else begin
            // out-of-range codes and unsupported passthrough fall to the slowest ratio
            mode_o.shift = SHIFT_W'(TOP_N);
        end
    end

endmodule

// File: rtl/card_clk_phase.sv
module card_clk_phase
    import card_clk_pkg::*;
#(
    parameter int TOP_N = MAX_CODE,
    localparam int CNT_W = (TOP_N > 0) ? TOP_N : 1
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      en_i,
    input  div_mode_t mode_i,
    output logic      clk_o,
    output logic      rise_o,
    output logic      byp_o
);

    typedef struct packed {
        logic               lvl;
        logic               rise;
        logic               byp;
        logic [CNT_W-1:0]   cnt;
        logic [SHIFT_W-1:0] shift;
    } phase_st_t;

    phase_st_t st_d, st_q;

    logic               at_start;
    logic [SHIFT_W-1:0] eff_shift;
    logic [CNT_W:0]     half_len;
    logic [CNT_W:0]     held_len;
    logic               half_last;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.byp  = 1'b0;
        // a period boundary: low level with a fresh counter
        at_start  = !st_q.lvl && (st_q.cnt == '0);
        eff_shift = at_start ? mode_i.shift : st_q.shift;
        half_len  = (CNT_W+1)'(1) << eff_shift;
        held_len  = (CNT_W+1)'(1) << st_q.shift;
        half_last = ({1'b0, st_q.cnt} == (half_len - (CNT_W+1)'(1)));

        if (!en_i) begin
            st_d.lvl = 1'b0;
            st_d.cnt = '0;
        end else if (at_start && mode_i.byp) begin
            st_d.byp  = 1'b1;
            st_d.rise = 1'b1;
            st_d.lvl  = 1'b0;
            st_d.cnt  = '0;
        end else begin
            if (at_start) begin
                st_d.shift = mode_i.shift;
            end
            if (half_last) begin
                st_d.lvl  = !st_q.lvl;
                st_d.cnt  = '0;
                st_d.rise = !st_q.lvl;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q       <= '0;
            st_q.shift <= SHIFT_W'(TOP_N);
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o  = st_q.lvl;
    assign rise_o = st_q.rise;
    assign byp_o  = st_q.byp;

    // R7: the held ratio may only change when the previous cycle was a boundary
    p_ratio_at_boundary_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.shift) |-> $past(at_start));

    // R2: the phase counter never runs past the half period of the held ratio
    p_cnt_in_half_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        {1'b0, st_q.cnt} < held_len);

    // R5: a low gate forces the clock and strobe low on the next cycle
    p_gate_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!st_q.lvl && !st_q.rise));

    // R6: a divided rising edge is always flagged by the strobe
    p_edge_flagged_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.lvl) |-> st_q.rise);

    // R6: outside passthrough the strobe only appears with a high level
    p_strobe_on_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.rise && !st_q.byp) |-> st_q.lvl);

    // R4: passthrough keeps the divided level low
    p_byp_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.byp |-> !st_q.lvl);

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import card_clk_pkg::*;
#(
    parameter int SEL_W = CODE_W,
    parameter int TOP_N = MAX_CODE
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clk_en_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic             bypass_strap_i,
    output logic             card_clk_o,
    output logic             card_rise_o,
    output logic             bypass_o
);

    div_mode_t mode;

    card_clk_decode #(
        .SEL_W (SEL_W),
        .TOP_N (TOP_N)
    ) decode_i (
        .sel_i   (div_sel_i),
        .strap_i (bypass_strap_i),
        .mode_o  (mode)
    );

    card_clk_phase #(
        .TOP_N (TOP_N)
    ) phase_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (clk_en_i),
        .mode_i (mode),
        .clk_o  (card_clk_o),
        .rise_o (card_rise_o),
        .byp_o  (bypass_o)
    );

    // R3: passthrough is only entered when the strap allowed it
    p_strap_gates_byp_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bypass_o) |-> $past(bypass_strap_i));

    // R4: passthrough strobes every cycle
    p_byp_strobe_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_o |-> card_rise_o);

    // R1: the first cycle after reset is idle
    p_reset_idle_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!card_clk_o && !card_rise_o && !bypass_o));

endmodule

// File: tb/card_clk_div_tb.sv
module card_clk_div_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [3:0] sel;
    logic       strap;
    logic       card_clk;
    logic       card_rise;
    logic       byp;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_div dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .clk_en_i       (en),
        .div_sel_i      (sel),
        .bypass_strap_i (strap),
        .card_clk_o     (card_clk),
        .card_rise_o    (card_rise),
        .bypass_o       (byp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Starts on a sample where the strobe is high; counts cycles up to the next strobe.
    task automatic measure(output int hi, output int per);
        bit prev_lvl;
        hi  = 0;
        per = 0;
        do begin
            if (card_clk) hi++;
            per++;
            prev_lvl = card_clk;
            @(negedge clk);
        end while (!card_rise && per < 2000);
        chk(card_clk == 1'b1 && prev_lvl == 1'b0, "R6", {30'd0, prev_lvl, card_clk}, 1);
    endtask

    task automatic stop_clock();
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!card_clk && !card_rise, "R5", {30'd0, card_clk, card_rise}, 0);
    endtask

    // Enables from idle and returns on the first strobe sample.
    task automatic start_clock(input int code, input int half);
        int i = 0;
        sel = code[3:0];
        en  = 1'b1;
        do begin
            @(negedge clk);
            i++;
        end while (!card_rise && i < 2000);
        chk(i == half, "R8", i, half);
    endtask

    task automatic t_reset();
        rst   = 1'b1;
        en    = 1'b1;
        sel   = 4'd0;
        strap = 1'b1;
        repeat (3) @(negedge clk);
        chk(!card_clk && !card_rise && !byp, "R1", {29'd0, card_clk, card_rise, byp}, 0);
        rst = 1'b0;
        en  = 1'b0;
        @(negedge clk);
        chk(!card_clk && !card_rise && !byp, "R1", {29'd0, card_clk, card_rise, byp}, 0);
        strap = 1'b0;
    endtask

    task automatic t_ratios();
        int hi, per;
        for (int n = 0; n <= 8; n++) begin
            start_clock(n, 1 << n);
            measure(hi, per);
            chk(per == (2 << n), "R2", per, 2 << n);
            chk(hi == (1 << n), "R2", hi, 1 << n);
            stop_clock();
        end
    endtask

    task automatic t_fallback();
        int hi, per;
        int codes[3] = '{9, 14, 15};
        strap = 1'b0;
        foreach (codes[k]) begin
            start_clock(codes[k], 256);
            measure(hi, per);
            chk(per == 512 && hi == 256, "R3", per, 512);
            chk(!byp, "R3", byp, 0);
            stop_clock();
        end
    endtask

    task automatic t_bypass();
        int hi, per;
        strap = 1'b1;
        sel   = 4'd15;
        en    = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(byp && card_rise && !card_clk, "R4", {29'd0, byp, card_rise, card_clk}, 6);
        end
        sel = 4'd1;
        @(negedge clk);
        chk(!byp, "R4", byp, 0);
        do @(negedge clk); while (!card_rise);
        measure(hi, per);
        chk(per == 4 && hi == 2, "R2", per, 4);
        stop_clock();
        strap = 1'b0;
    endtask

    task automatic t_switch();
        int hi, per;
        start_clock(2, 4);
        sel = 4'd0;
        measure(hi, per);
        chk(per == 5 && hi == 4, "R7", per, 5);
        measure(hi, per);
        chk(per == 2 && hi == 1, "R7", per, 2);
        sel = 4'd3;
        measure(hi, per);
        chk(per == 9 && hi == 1, "R7", per, 9);
        measure(hi, per);
        chk(per == 16 && hi == 8, "R7", per, 16);
        stop_clock();
    endtask

    task automatic t_gate_mid();
        bit seen = 0;
        start_clock(3, 8);
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!card_clk && !card_rise, "R5", {30'd0, card_clk, card_rise}, 0);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (card_clk || card_rise) seen = 1;
        end
        chk(!seen, "R5", seen, 0);
        start_clock(3, 8);
        stop_clock();
    endtask

    initial begin
        t_reset();
        t_ratios();
        t_fallback();
        t_bypass();
        t_switch();
        t_gate_mid();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule